// File: doc/BRIEF.md
# Serial pattern-unlock register access controller

This block sits between a host memory bus and the chip enable of an external memory. It watches chip-enabled bus cycles and keeps a small timekeeper register file hidden until the host writes a 64-bit key. The key goes in one bit per write cycle on the data-in line. While the key is not yet recognised, every bus cycle is passed straight through to the memory. Once the key matches, the next 64 bus cycles move data between the host and the eight 8-bit registers, one bit per cycle. During that window the memory chip enable is held off.

Bus cycles are taken at the rising edge of the chip enable. All pins are brought into the system clock domain through two-flop synchronisers. Two conditions abort a transfer without touching a register that was not yet completed: an external reset pin, which can be masked, and a power-fail flag. The power-fail flag also forces the memory chip enable to a level set by a RAM/ROM mode input.

Top module: `keyed_serial_regfile_ctl`

## Requirements
- R1: After system reset and while the key is not recognised, `mem_ce_n` follows `bus_ce_n`, `bus_dout` is 0 and the register file reads back as all zeros.
- R2: The block unlocks after 64 consecutive matching write cycles. The key bytes are C5, 3A, A3, 5C, C5, 3A, A3, 5C in that order, and each byte is compared LSB first.
- R3: A write whose data bit differs from the expected key bit stops the match. Every further write is then ignored, and the block stays locked, until a read cycle occurs.
- R4: A read cycle during key matching restarts the comparison at the first key bit.
- R5: After unlock, exactly 64 bus cycles form the transfer window. `mem_ce_n` is 1 throughout the window, and it follows `bus_ce_n` again from the next cycle on.
- R6: Each transfer cycle gives one `xfer_stb` pulse. `xfer_idx` equals register*8+bit and steps 0..63, so the order runs from bit 0 of register 0 to bit 7 of register 7.
- R7: A transfer read places the addressed register bit on `bus_dout` while the bus cycle is active. Transfer writes are committed one whole register at a time, on that register's eighth cycle. Bits that were read in that register keep their stored value.
- R8: With `rst_ign` = 0, a low `rtc_rst_n` aborts the window or key match. A register whose eight cycles were not all completed keeps its old value.
- R9: With `rst_ign` = 1, `rtc_rst_n` has no effect on matching or transfer.
- R10: While `pwr_fail` is 1, any window or match is aborted, and all bus cycles are ignored by the key and transfer logic.
- R11: While `pwr_fail` is 1, `mem_ce_n` is 1 with `rom_mode` = 0 and 0 with `rom_mode` = 1, regardless of `bus_ce_n`.
- R12: A cycle is a write if `bus_we_n` is low and a read if `bus_oe_n` is low with `bus_we_n` high. A chip-enable pulse with both high is ignored and does not disturb key matching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low system reset |
| bus_ce_n | input | 1 | Bus chip enable, active low; a cycle ends on its rising edge |
| bus_oe_n | input | 1 | Bus output enable, active low |
| bus_we_n | input | 1 | Bus write enable, active low |
| bus_din | input | 1 | Serial data-in bit |
| rtc_rst_n | input | 1 | Abort pin, active low |
| rst_ign | input | 1 | 1 = abort pin ignored |
| pwr_fail | input | 1 | Power-fail flag, active high |
| rom_mode | input | 1 | 1 = ROM mode, 0 = RAM mode for power-fail chip enable level |
| bus_dout | output | 1 | Serial data-out bit during transfer reads |
| mem_ce_n | output | 1 | Chip enable to the external memory, active low |
| xfer_stb | output | 1 | One-clock pulse per accepted transfer cycle |
| xfer_we | output | 1 | Transfer cycle was a write (valid with `xfer_stb`) |
| xfer_idx | output | 6 | Bit position of the transfer cycle, register*8+bit |

## Verification
A wrong key pointer or a stuck miss flag shows as `mem_ce_n` still following `bus_ce_n` after a full key, or going high when it should not. This is visible within one bus cycle of the 64th key write. A wrong transfer pointer or staging byte shows as a wrong `bus_dout` bit or a misnumbered `xfer_idx` on the very cycle it happens. A premature or lost commit only shows up on the next read-back window, where the byte disagrees with the model. Aborts are checked by comparing the register that was cut short against its earlier value.

// File: rtl/kru_pkg.sv
package kru_pkg;
    localparam int KRU_NREG = 8;
    localparam int KRU_RW   = 8;
    localparam int KRU_NB   = KRU_NREG * KRU_RW;
    // key bytes packed so bit i is byte i/8, bit i%8 (LSB first)
    localparam logic [KRU_NB-1:0] KRU_KEY = 64'h5CA3_3AC5_5CA3_3AC5;

    typedef enum logic {
        MODE_MATCH = 1'b0,
        MODE_XFER  = 1'b1
    } mode_e;
endpackage

// File: rtl/kru_sync.sv
module kru_sync #(
    parameter int W = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] a,
    output logic [W-1:0] y
);
    logic [W-1:0] s1_q;
    logic [W-1:0] s2_q;

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                s1_q[i] <= RST_VAL[i];
                s2_q[i] <= RST_VAL[i];
            end else begin
                s1_q[i] <= a[i];
                s2_q[i] <= s1_q[i];
            end
        end
    end

    assign y = s2_q;
endmodule

// File: rtl/kru_cycle_det.sv
module kru_cycle_det (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n_s,
    input  logic oe_n_s,
    input  logic we_n_s,
    input  logic din_s,
    output logic ev_rd,
    output logic ev_wr,
    output logic ev_din
);
    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic we_n;
        logic din;
    } det_t;

    det_t d, q;
    logic ce_rise;

    always_comb begin
        d.ce_n  = ce_n_s;
        d.oe_n  = oe_n_s;
        d.we_n  = we_n_s;
        d.din   = din_s;
        ce_rise = ce_n_s & ~q.ce_n;
        ev_wr   = ce_rise & ~q.we_n;
        ev_rd   = ce_rise & ~q.oe_n & q.we_n;
        ev_din  = q.din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, din: 1'b0};
        else        q <= d;
    end

    // R12
    one_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_rd || ev_wr) |=> !(ev_rd || ev_wr));
endmodule

// File: rtl/kru_regfile.sv
module kru_regfile #(
    parameter int NREG = 8,
    parameter int RW   = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [$clog2(NREG)-1:0] wr_idx,
    input  logic [RW-1:0]           wr_byte,
    output logic [NREG*RW-1:0]      regs
);
    logic [NREG*RW-1:0] regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) regs_d[wr_idx*RW +: RW] = wr_byte;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign regs = regs_q;

    // R7
    hold_unless_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> regs_q == $past(regs_q));
endmodule

// File: rtl/kru_access_fsm.sv
module kru_access_fsm
    import kru_pkg::*;
#(
    parameter int NREG = KRU_NREG,
    parameter int RW   = KRU_RW,
    parameter logic [NREG*RW-1:0] KEY = KRU_KEY
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         ev_rd,
    input  logic                         ev_wr,
    input  logic                         din,
    input  logic                         abort,
    input  logic                         rd_bit,
    output logic                         xfer_mode,
    output logic [$clog2(NREG*RW)-1:0]   ptr,
    output logic                         stb,
    output logic                         stb_we,
    output logic                         cm_en,
    output logic [$clog2(NREG)-1:0]      cm_idx,
    output logic [RW-1:0]                cm_byte
);
    localparam int NB = NREG * RW;
    localparam int PW = $clog2(NB);
    localparam int BW = $clog2(RW);
    localparam logic [PW-1:0] LAST = PW'(NB - 1);
    localparam logic [BW-1:0] BLAST = BW'(RW - 1);

    typedef struct packed {
        mode_e         mode;
        logic [PW-1:0] ptr;
        logic          miss;
        logic [RW-1:0] stage;
    } fsm_t;

    fsm_t d, q;

    always_comb begin
        d       = q;
        stb     = 1'b0;
        stb_we  = 1'b0;
        cm_en   = 1'b0;
        cm_idx  = q.ptr[PW-1:BW];
        cm_byte = q.stage;
        if (abort) begin
            d.mode = MODE_MATCH;
            d.ptr  = '0;
            d.miss = 1'b0;
        end else if (q.mode == MODE_MATCH) begin
            if (ev_rd) begin
                d.ptr  = '0;
                d.miss = 1'b0;
            end else if (ev_wr && !q.miss) begin
                if (din == KEY[q.ptr]) begin
                    if (q.ptr == LAST) begin
                        d.mode = MODE_XFER;
                        d.ptr  = '0;
                    end else begin
                        d.ptr = q.ptr + 1'b1;
                    end
                end else begin
                    d.miss = 1'b1;
                end
            end
        end else if (ev_rd || ev_wr) begin
            stb    = 1'b1;
            stb_we = ev_wr;
            d.stage[q.ptr[BW-1:0]] = ev_wr ? din : rd_bit;
            if (q.ptr[BW-1:0] == BLAST) begin
                cm_en   = 1'b1;
                cm_byte = d.stage;
            end
            if (q.ptr == LAST) begin
                d.mode = MODE_MATCH;
                d.ptr  = '0;
                d.miss = 1'b0;
            end else begin
                d.ptr = q.ptr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{mode: MODE_MATCH, ptr: '0, miss: 1'b0, stage: '0};
        else        q <= d;
    end

    assign xfer_mode = (q.mode == MODE_XFER);
    assign ptr       = q.ptr;

    // R8
    abort_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (q.mode == MODE_MATCH) && (q.ptr == '0) && !q.miss);
    // R3
    miss_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.mode == MODE_MATCH && q.miss && !ev_rd && !abort)
            |=> q.miss && q.ptr == $past(q.ptr) && q.mode == MODE_MATCH);
    // R6
    xfer_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.mode == MODE_XFER && (ev_rd || ev_wr) && !abort && q.ptr != LAST)
            |=> q.mode == MODE_XFER && q.ptr == $past(q.ptr) + 1'b1);
    // R5
    xfer_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.mode == MODE_XFER && (ev_rd || ev_wr) && !abort && q.ptr == LAST)
            |=> q.mode == MODE_MATCH && q.ptr == '0);
    // R5
    xfer_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.mode == MODE_XFER && !ev_rd && !ev_wr && !abort)
            |=> q.mode == MODE_XFER && $stable(q.ptr));
endmodule

// File: rtl/keyed_serial_regfile_ctl.sv
module keyed_serial_regfile_ctl
    import kru_pkg::*;
#(
    parameter int NREG = KRU_NREG,
    parameter int RW   = KRU_RW,
    parameter logic [NREG*RW-1:0] KEY = KRU_KEY
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_ce_n,
    input  logic                        bus_oe_n,
    input  logic                        bus_we_n,
    input  logic                        bus_din,
    input  logic                        rtc_rst_n,
    input  logic                        rst_ign,
    input  logic                        pwr_fail,
    input  logic                        rom_mode,
    output logic                        bus_dout,
    output logic                        mem_ce_n,
    output logic                        xfer_stb,
    output logic                        xfer_we,
    output logic [$clog2(NREG*RW)-1:0]  xfer_idx
);
    localparam int NB = NREG * RW;
    localparam int PW = $clog2(NB);
    localparam int IW = $clog2(NREG);
    localparam int NS = 7;
    // order: ce_n, oe_n, we_n, din, rtc_rst_n, rst_ign, pwr_fail
    localparam logic [NS-1:0] SYNC_RST = 7'b1110100;

    logic [NS-1:0] s;
    logic ce_n_s, oe_n_s, we_n_s, din_s, rtcr_n_s, ign_s, pf_s;
    logic ev_rd, ev_wr, ev_din, abort, rd_bit, xfer_mode;
    logic [PW-1:0] ptr;
    logic cm_en;
    logic [IW-1:0] cm_idx;
    logic [RW-1:0] cm_byte;
    logic [NB-1:0] regs;

    kru_sync #(.W(NS), .RST_VAL(SYNC_RST)) u_sync (
        .clk (clk),
        .rst_n (rst_n),
        .a ({bus_ce_n, bus_oe_n, bus_we_n, bus_din, rtc_rst_n, rst_ign, pwr_fail}),
        .y (s)
    );

    assign {ce_n_s, oe_n_s, we_n_s, din_s, rtcr_n_s, ign_s, pf_s} = s;
    assign abort = pf_s | (~rtcr_n_s & ~ign_s);

    kru_cycle_det u_det (
        .clk (clk), .rst_n (rst_n),
        .ce_n_s (ce_n_s), .oe_n_s (oe_n_s), .we_n_s (we_n_s), .din_s (din_s),
        .ev_rd (ev_rd), .ev_wr (ev_wr), .ev_din (ev_din)
    );

    kru_access_fsm #(.NREG(NREG), .RW(RW), .KEY(KEY)) u_fsm (
        .clk (clk), .rst_n (rst_n),
        .ev_rd (ev_rd), .ev_wr (ev_wr), .din (ev_din), .abort (abort),
        .rd_bit (rd_bit), .xfer_mode (xfer_mode), .ptr (ptr),
        .stb (xfer_stb), .stb_we (xfer_we),
        .cm_en (cm_en), .cm_idx (cm_idx), .cm_byte (cm_byte)
    );

    kru_regfile #(.NREG(NREG), .RW(RW)) u_rf (
        .clk (clk), .rst_n (rst_n),
        .wr_en (cm_en), .wr_idx (cm_idx), .wr_byte (cm_byte),
        .regs (regs)
    );

    assign rd_bit   = regs[ptr];
    assign xfer_idx = ptr;
    assign bus_dout = xfer_mode ? rd_bit : 1'b0;
    assign mem_ce_n = pf_s ? ~rom_mode : (xfer_mode | bus_ce_n);

    // R10
    no_commit_in_pf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pf_s |-> !cm_en && !xfer_stb);
endmodule

// File: tb/sim_keyed_serial_regfile_ctl.sv
module sim_keyed_serial_regfile_ctl;
    localparam time CYC = 10ns;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, din = 1'b0;
    logic rtcr_n = 1'b1, ign = 1'b0, pf = 1'b0, rom = 1'b0;
    logic dout, mce_n, stb, xwe;
    logic [5:0] idx;

    always #(CYC/2) clk = ~clk;

    keyed_serial_regfile_ctl u0 (
        .clk (clk), .rst_n (rst_n),
        .bus_ce_n (ce_n), .bus_oe_n (oe_n), .bus_we_n (we_n), .bus_din (din),
        .rtc_rst_n (rtcr_n), .rst_ign (ign), .pwr_fail (pf), .rom_mode (rom),
        .bus_dout (dout), .mem_ce_n (mce_n),
        .xfer_stb (stb), .xfer_we (xwe), .xfer_idx (idx)
    );

    int checks = 0;
    int errors = 0;
    bit settle = 1'b1;
    bit done = 1'b0;

    // behavioural reference state
    bit [7:0] kb [8] = '{8'hC5, 8'h3A, 8'hA3, 8'h5C, 8'hC5, 8'h3A, 8'hA3, 8'h5C};
    bit       m_xfer = 1'b0;
    int       m_ptr  = 0;
    bit       m_miss = 1'b0;
    bit [7:0] m_regs [8];
    bit [7:0] m_stage = 8'h00;
    int       stb_seen = 0;

    bit [7:0] wbuf [8];
    bit [7:0] got  [8];
    bit [7:0] expv [8];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic bit keybit(input int i);
        return kb[i/8][i%8];
    endfunction

    function automatic bit m_aborting();
        return pf || (!rtcr_n && !ign);
    endfunction

    task automatic m_abort();
        m_xfer = 1'b0;
        m_ptr  = 0;
        m_miss = 1'b0;
        stb_seen = 0;
    endtask

    task automatic m_cycle(input bit wr, input bit rd, input bit d);
        if (m_aborting()) return;
        if (!wr && !rd) return;
        if (!m_xfer) begin
            if (!wr) begin
                m_ptr = 0;
                m_miss = 1'b0;
            end else if (!m_miss) begin
                if (d == keybit(m_ptr)) begin
                    if (m_ptr == 63) begin m_xfer = 1'b1; m_ptr = 0; end
                    else m_ptr++;
                end else m_miss = 1'b1;
            end
        end else begin
            m_stage[m_ptr%8] = wr ? d : m_regs[m_ptr/8][m_ptr%8];
            if (m_ptr % 8 == 7) m_regs[m_ptr/8] = m_stage;
            if (m_ptr == 63) begin m_xfer = 1'b0; m_ptr = 0; m_miss = 1'b0; end
            else m_ptr++;
        end
    endtask

    // per-clock comparison against the reference
    always @(negedge clk) begin
        if (!settle && !done) begin
            automatic bit exp_ce = pf ? !rom : (m_xfer ? 1'b1 : ce_n);
            automatic bit exp_do = m_xfer ? m_regs[m_ptr/8][m_ptr%8] : 1'b0;
            chk(mce_n == exp_ce, pf ? "R11" : (m_xfer ? "R5" : "R1"),
                "mem_ce_n", 64'(mce_n), 64'(exp_ce));
            chk(dout == exp_do, m_xfer ? "R7" : "R1", "bus_dout", 64'(dout), 64'(exp_do));
        end
        if (stb && !done) begin
            chk(idx == 6'(stb_seen % 64), "R6", "xfer_idx order", 64'(idx), 64'(stb_seen % 64));
            stb_seen++;
        end
    end

    task automatic bus_op(input bit wr, input bit rd, input bit d,
                          output bit ce_seen, output bit do_seen);
        @(posedge clk); #2;
        ce_n = 1'b0; oe_n = !rd; we_n = !wr; din = d;
        repeat (3) @(posedge clk);
        @(negedge clk);
        ce_seen = mce_n;
        do_seen = dout;
        @(posedge clk); #2;
        settle = 1'b1;
        ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
        m_cycle(wr, rd, d);
        repeat (5) @(posedge clk);
        #2 settle = 1'b0;
    endtask

    task automatic op_wr(input bit d);
        bit a, b;
        bus_op(1'b1, 1'b0, d, a, b);
    endtask

    task automatic op_rd(output bit d);
        bit a;
        bus_op(1'b0, 1'b1, 1'b0, a, d);
    endtask

    task automatic send_key(input bit with_idle);
        bit a, b;
        for (int i = 0; i < 64; i++) begin
            op_wr(keybit(i));
            if (with_idle && (i % 9 == 4)) bus_op(1'b0, 1'b0, 1'b1, a, b);
        end
    endtask

    task automatic write_bits(input int from, input int to);
        for (int i = from; i < to; i++) op_wr(wbuf[i/8][i%8]);
    endtask

    task automatic unlock();
        bit r;
        op_rd(r);
        send_key(1'b0);
    endtask

    task automatic read_all();
        bit r;
        int s0;
        unlock();
        s0 = stb_seen;
        for (int i = 0; i < 64; i++) begin
            op_rd(r);
            got[i/8][i%8] = r;
        end
        chk(stb_seen - s0 == 64, "R6", "strobes per read window", 64'(stb_seen - s0), 64);
    endtask

    task automatic cmp_all(input string req);
        for (int i = 0; i < 8; i++)
            chk(got[i] == expv[i], req, $sformatf("register %0d", i), 64'(got[i]), 64'(expv[i]));
    endtask

    task automatic set_in(input bit new_pf, input bit new_rtcr, input bit new_ign, input bit new_rom);
        @(posedge clk); #2;
        settle = 1'b1;
        pf = new_pf; rtcr_n = new_rtcr; ign = new_ign; rom = new_rom;
        if (m_aborting()) m_abort();
        repeat (5) @(posedge clk);
        #2 settle = 1'b0;
    endtask

    initial begin
        #(CYC * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        bit cs, dv;
        int s0;
        for (int i = 0; i < 8; i++) m_regs[i] = 8'h00;
        repeat (4) @(posedge clk);
        #2 rst_n = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk(mce_n == 1'b1, "R1", "reset mem_ce_n", 64'(mce_n), 1);
        chk(dout == 1'b0, "R1", "reset bus_dout", 64'(dout), 0);
        chk(stb == 1'b0, "R1", "reset xfer_stb", 64'(stb), 0);
        settle = 1'b0;

        // R1: registers read back as zeros
        read_all();
        for (int i = 0; i < 8; i++) expv[i] = 8'h00;
        cmp_all("R1");

        // R2/R7: unlock with the key and write a full pattern
        wbuf = '{8'hA5, 8'h3C, 8'h0F, 8'hF0, 8'h5A, 8'hC3, 8'h96, 8'h69};
        unlock();
        s0 = stb_seen;
        bus_op(1'b1, 1'b0, wbuf[0][0], cs, dv);
        chk(cs == 1'b1, "R5", "mem_ce_n during first transfer", 64'(cs), 1);
        write_bits(1, 64);
        chk(stb_seen - s0 == 64, "R6", "strobes per write window", 64'(stb_seen - s0), 64);
        // R5: the 65th cycle goes to memory
        bus_op(1'b1, 1'b0, 1'b1, cs, dv);
        chk(cs == 1'b0, "R5", "mem_ce_n after window", 64'(cs), 0);
        read_all();
        expv = wbuf;
        cmp_all("R2");

        // R3: corrupted key bit, then more writes; must stay locked
        op_rd(dv);
        for (int i = 0; i < 64; i++) op_wr(i == 5 ? !keybit(i) : keybit(i));
        for (int i = 0; i < 8; i++) op_wr(1'b0);
        bus_op(1'b1, 1'b0, 1'b0, cs, dv);
        chk(cs == 1'b0, "R3", "still locked after bad key", 64'(cs), 0);
        read_all();
        cmp_all("R3");

        // R4: partial key, then read_all restarts with a read
        op_rd(dv);
        for (int i = 0; i < 30; i++) op_wr(keybit(i));
        read_all();
        cmp_all("R4");

        // R12: idle chip-enable pulses interleaved in the key
        wbuf = '{8'h5A, 8'hC3, 8'hF0, 8'h0F, 8'hA5, 8'h3C, 8'h69, 8'h96};
        op_rd(dv);
        send_key(1'b1);
        write_bits(0, 64);
        read_all();
        expv = wbuf;
        cmp_all("R12");

        // R8: abort pin mid register 3
        wbuf = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66, 8'h77, 8'h88};
        unlock();
        write_bits(0, 28);
        set_in(1'b0, 1'b0, 1'b0, 1'b0);
        bus_op(1'b1, 1'b0, 1'b1, cs, dv);
        chk(cs == 1'b0, "R8", "mem_ce_n after abort", 64'(cs), 0);
        set_in(1'b0, 1'b1, 1'b0, 1'b0);
        read_all();
        expv = '{8'h11, 8'h22, 8'h33, 8'h0F, 8'hA5, 8'h3C, 8'h69, 8'h96};
        cmp_all("R8");

        // R9: pin masked, transfer continues
        wbuf = '{8'hE1, 8'hD2, 8'hC3, 8'hB4, 8'hA5, 8'h96, 8'h87, 8'h78};
        set_in(1'b0, 1'b1, 1'b1, 1'b0);
        unlock();
        write_bits(0, 12);
        set_in(1'b0, 1'b0, 1'b1, 1'b0);
        bus_op(1'b1, 1'b0, wbuf[1][4], cs, dv);
        chk(cs == 1'b1, "R9", "window kept with pin masked", 64'(cs), 1);
        write_bits(13, 64);
        set_in(1'b0, 1'b1, 1'b1, 1'b0);
        set_in(1'b0, 1'b1, 1'b0, 1'b0);
        read_all();
        expv = wbuf;
        cmp_all("R9");

        // R10/R11: power fail mid register 1 in RAM mode
        wbuf = '{8'h0A, 8'h0B, 8'h0C, 8'h0D, 8'h0E, 8'h0F, 8'h10, 8'h20};
        unlock();
        write_bits(0, 12);
        set_in(1'b1, 1'b1, 1'b0, 1'b0);
        bus_op(1'b0, 1'b1, 1'b0, cs, dv);
        chk(cs == 1'b1, "R11", "RAM mode mem_ce_n in power fail", 64'(cs), 1);
        s0 = stb_seen;
        op_rd(dv);
        send_key(1'b0);
        bus_op(1'b0, 1'b1, 1'b0, cs, dv);
        chk(stb_seen == s0, "R10", "no strobes in power fail", 64'(stb_seen), 64'(s0));
        chk(dv == 1'b0, "R10", "no data out in power fail", 64'(dv), 0);
        set_in(1'b0, 1'b1, 1'b0, 1'b0);
        bus_op(1'b1, 1'b0, 1'b1, cs, dv);
        chk(cs == 1'b0, "R10", "locked after power returns", 64'(cs), 0);
        read_all();
        expv = '{8'h0A, 8'hD2, 8'hC3, 8'hB4, 8'hA5, 8'h96, 8'h87, 8'h78};
        cmp_all("R10");

        // R11: ROM mode forces memory enable low
        set_in(1'b0, 1'b1, 1'b0, 1'b1);
        set_in(1'b1, 1'b1, 1'b0, 1'b1);
        @(negedge clk);
        chk(mce_n == 1'b0, "R11", "ROM mode mem_ce_n idle bus", 64'(mce_n), 0);
        set_in(1'b0, 1'b1, 1'b0, 1'b1);
        @(negedge clk);
        chk(mce_n == 1'b1, "R11", "ROM mode pass-through after fail", 64'(mce_n), 1);
        set_in(1'b0, 1'b1, 1'b0, 1'b0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule